// File: doc/BRIEF.md
# Polarity-Configurable GPIO Register Bank

This block is the register core of an eight-pin general-purpose I/O port. A bus front end, outside the block, turns its transfers into a write strobe, a read strobe, a two-bit register index and a data byte. The bank holds four registers. The first is a read-only view of the pin levels. The second holds output drive values. The third holds a per-pin inversion mask, which changes how input levels are reported. The fourth holds direction bits. From these registers the bank produces a drive value and an output enable for every pin.

Pins 1 to 7 are push-pull. Pin 0 can only sink current. When pin 0 is an output holding a 1, it releases the line, and the pull-up outside the chip sets the level.

Pin levels pass through a two-flop synchronizer. A read loads a read-data register, so each bus read returns one stable snapshot. An active-low asynchronous reset and a synchronous reset each restore every register to its default.

Top module: `gpio_reg_bank`

## Requirements
- R1: A write strobe with index 1 (output), 2 (inversion) or 3 (direction) stores the write data in that register. A later read of the same index returns it.
- R2: A write with index 0 changes no register and no pin output.
- R3: A read of index 0 returns the synchronized pin levels, whatever direction each pin is set to. A pin change that is driven just before a clock edge is first seen by a read strobe sampled at the third edge after that change.
- R4: A direction bit of 1 deasserts that pin's output enable. A direction bit of 0 on pins 1 to 7 asserts the enable, and the pin drive equals the stored output bit.
- R5: A read of index 1 returns the stored output register, not the pin level.
- R6: Pin 0 always drives 0. Its enable is asserted only when its direction bit is 0 and its output bit is 0.
- R7: After reset the output register is 0x00, the inversion register is 0xF0, the direction register is 0xFF and the read data is 0x00. All pins are therefore inputs.
- R8: Either reset restores the R7 defaults. While the asynchronous reset is held low, the defaults hold even if write strobes arrive.
- R9: Read data changes only on a read strobe. It is valid from the clock edge that samples the strobe and holds until the next read.
- R10: An inversion bit of 1 inverts the reported level of that pin on an index-0 read. An inversion bit of 0 reports the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncRst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regSel | input | 2 | Register index (0 input, 1 output, 2 inversion, 3 direction) |
| wrData | input | 8 | Write data |
| pinIn | input | 8 | Pin levels, asynchronous |
| rdData | output | 8 | Read data snapshot |
| pinOut | output | 8 | Per-pin drive value |
| pinOe | output | 8 | Per-pin output enable |

## Verification
The bench accounts for the latency of each result. A write changes register contents and pin drive one edge after the write strobe is sampled. Read data appears one edge after the read strobe is sampled. A pin change needs two edges in the synchronizer, so a read is first able to see it at the third edge after the change.

The bench drives all stimulus and samples all results on falling edges. Each check therefore falls after exactly the number of rising edges counted above. The two-edge pin latency is checked with back-to-back reads: they must return the old level twice and then the new level. The asynchronous reset is checked between edges, before any clock edge can mask it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    IDX_IN  = 2'd0,
    IDX_OUT = 2'd1,
    IDX_POL = 2'd2,
    IDX_CFG = 2'd3
  } regIdx_t;

  typedef struct packed {
    logic    wrOut;
    logic    wrPol;
    logic    wrCfg;
    logic    rdLoad;
    regIdx_t rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  regSel,
  output bankStrobe_t strobe
);

  regIdx_t idx;
  assign idx = regIdx_t'(regSel);

  always_comb begin
    strobe        = '0;
    strobe.rdLoad = rdEn;
    strobe.rdSel  = idx;
    if (wrEn) begin
      unique case (idx)
        IDX_OUT: strobe.wrOut = 1'b1;
        IDX_POL: strobe.wrPol = 1'b1;
        IDX_CFG: strobe.wrCfg = 1'b1;
        default: ;  // input view is read-only
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] OUT_RST = '0,
  parameter logic [WIDTH-1:0] POL_RST = {{(WIDTH/2){1'b1}}, {(WIDTH-WIDTH/2){1'b0}}},
  parameter logic [WIDTH-1:0] CFG_RST = '1,
  parameter logic [WIDTH-1:0] OD_MASK = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncRst,
  input  bankStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] outReg, polReg, cfgReg;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;
  logic [WIDTH-1:0] pinLevel, rdMux;

  assign pinLevel = syncQ[LAST] ^ polReg;

  always_comb begin
    unique case (strobe.rdSel)
      IDX_IN:  rdMux = pinLevel;
      IDX_OUT: rdMux = outReg;
      IDX_POL: rdMux = polReg;
      default: rdMux = cfgReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= OUT_RST;
      polReg <= POL_RST;
      cfgReg <= CFG_RST;
      syncQ  <= '0;
      rdData <= '0;
    end else if (syncRst) begin
      outReg <= OUT_RST;
      polReg <= POL_RST;
      cfgReg <= CFG_RST;
      syncQ  <= '0;
      rdData <= '0;
    end else begin
      if (strobe.wrOut) outReg <= wrData;
      if (strobe.wrPol) polReg <= wrData;
      if (strobe.wrCfg) cfgReg <= wrData;
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      if (strobe.rdLoad) rdData <= rdMux;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    if (OD_MASK[b]) begin : g_sink
      assign pinOut[b] = 1'b0;
      assign pinOe[b]  = ~cfgReg[b] & ~outReg[b];
    end else begin : g_push
      assign pinOut[b] = outReg[b];
      assign pinOe[b]  = ~cfgReg[b];
    end
  end

  // R1: a write strobe lands in its register
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCfg && !syncRst) |=> cfgReg == $past(wrData));

  // R2: with no write strobe the registers do not move
  p_idle_regs_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrOut && !strobe.wrPol && !strobe.wrCfg && !syncRst)
      |=> ($stable(outReg) && $stable(polReg) && $stable(cfgReg)));

  // R4: no input pin is driven
  p_inputs_float_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & cfgReg) == '0);

  // R5: output readback returns the register contents
  p_out_readback_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLoad && strobe.rdSel == IDX_OUT && !syncRst) |=> rdData == $past(outReg));

  // R8: synchronous reset restores defaults
  p_sync_defaults_r8: assert property (@(posedge clk) disable iff (!rstN)
    syncRst |=> (outReg == OUT_RST && polReg == POL_RST && cfgReg == CFG_RST));

  // R9: read data holds between read strobes
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rdLoad && !syncRst) |=> $stable(rdData));

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncRst,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       regSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);

  bankStrobe_t strobe;

  gpio_bank_ctrl u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .regSel (regSel),
    .strobe (strobe)
  );

  gpio_bank_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .syncRst (syncRst),
    .strobe  (strobe),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .rdData  (rdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );

  // R6: pin 0 never drives high
  p_sink_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    pinOe[0] |-> !pinOut[0]);

endmodule

// File: tb/tb_gpio_reg_bank.sv
module tb_gpio_reg_bank;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncRst = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] pinIn = 8'h00;
  logic [7:0] rdData, pinOut, pinOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_reg_bank dut (
    .clk(clk), .rstN(rstN), .syncRst(syncRst), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .wrData(wrData), .pinIn(pinIn),
    .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic writeReg(input logic [1:0] sel, input logic [7:0] d);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] v);
    rdEn = 1'b1; regSel = sel;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic settlePins(input logic [7:0] p);
    pinIn = p;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R7", "rdData after reset", rdData, 8'h00);
    check("R7", "pinOe after reset", pinOe, 8'h00);
    readReg(2'd1, v); check("R7", "output default", v, 8'h00);
    readReg(2'd2, v); check("R7", "inversion default", v, 8'hF0);
    readReg(2'd3, v); check("R7", "direction default", v, 8'hFF);
  endtask

  task automatic testWrite();
    logic [7:0] v;
    writeReg(2'd1, 8'hA5);
    writeReg(2'd2, 8'h3C);
    writeReg(2'd3, 8'h00);
    readReg(2'd1, v); check("R1", "output readback", v, 8'hA5);
    readReg(2'd2, v); check("R1", "inversion readback", v, 8'h3C);
    readReg(2'd3, v); check("R1", "direction readback", v, 8'h00);
    check("R4", "enables all outputs, pin0 released", pinOe, 8'hFE);
    check("R4", "drive push-pull bits", pinOut, 8'hA4);
  endtask

  task automatic testIdx0Write();
    logic [7:0] v;
    writeReg(2'd0, 8'h5A);
    readReg(2'd1, v); check("R2", "output after idx0 write", v, 8'hA5);
    readReg(2'd2, v); check("R2", "inversion after idx0 write", v, 8'h3C);
    readReg(2'd3, v); check("R2", "direction after idx0 write", v, 8'h00);
    check("R2", "pinOe after idx0 write", pinOe, 8'hFE);
    check("R2", "pinOut after idx0 write", pinOut, 8'hA4);
  endtask

  task automatic testInputPolarity();
    logic [7:0] v;
    settlePins(8'h0F);
    readReg(2'd0, v); check("R10", "inverted input with pins as outputs (R3)", v, 8'h33);
    writeReg(2'd2, 8'h00);
    readReg(2'd0, v); check("R10", "uninverted input", v, 8'h0F);
  endtask

  task automatic testSyncDelay();
    logic [7:0] v;
    settlePins(8'h00);
    pinIn = 8'hFF;
    readReg(2'd0, v); check("R3", "first edge after change", v, 8'h00);
    readReg(2'd0, v); check("R3", "second edge after change", v, 8'h00);
    readReg(2'd0, v); check("R3", "third edge after change", v, 8'hFF);
  endtask

  task automatic testSnapshot();
    pinIn = 8'h00;
    repeat (4) @(negedge clk);
    check("R9", "rdData holds without read", rdData, 8'hFF);
  endtask

  task automatic testOutReadback();
    logic [7:0] v;
    writeReg(2'd3, 8'hFF);
    writeReg(2'd1, 8'h81);
    readReg(2'd1, v); check("R5", "output reg not pin level", v, 8'h81);
    check("R4", "inputs not enabled", pinOe, 8'h00);
  endtask

  task automatic testOpenDrain();
    writeReg(2'd3, 8'h00);
    writeReg(2'd1, 8'h00);
    check("R6", "pin0 sinks on 0 oe", pinOe, 8'hFF);
    check("R6", "pin0 sinks on 0 drive", pinOut, 8'h00);
    writeReg(2'd1, 8'h01);
    check("R6", "pin0 released on 1", pinOe, 8'hFE);
    check("R6", "pin0 drive stays low", pinOut, 8'h00);
    writeReg(2'd1, 8'hFE);
    check("R6", "high drive on push-pull", pinOut, 8'hFE);
    writeReg(2'd1, 8'h00);
    writeReg(2'd3, 8'h01);
    check("R6", "pin0 input not enabled", pinOe, 8'hFE);
  endtask

  task automatic testSyncReset();
    logic [7:0] v;
    writeReg(2'd2, 8'h55);
    syncRst = 1'b1;
    @(negedge clk);
    syncRst = 1'b0;
    check("R8", "pinOe after sync reset", pinOe, 8'h00);
    check("R8", "rdData after sync reset", rdData, 8'h00);
    readReg(2'd1, v); check("R8", "output after sync reset", v, 8'h00);
    readReg(2'd2, v); check("R8", "inversion after sync reset", v, 8'hF0);
    readReg(2'd3, v); check("R8", "direction after sync reset", v, 8'hFF);
  endtask

  task automatic testAsyncReset();
    logic [7:0] v;
    writeReg(2'd3, 8'h00);
    writeReg(2'd1, 8'h55);
    #2 rstN = 1'b0;
    #1 check("R8", "pinOe drops without edge", pinOe, 8'h00);
    @(negedge clk);
    wrEn = 1'b1; regSel = 2'd3; wrData = 8'h00;
    repeat (3) @(negedge clk);
    check("R8", "held in reset despite writes", pinOe, 8'h00);
    wrEn = 1'b0; rstN = 1'b1;
    @(negedge clk);
    readReg(2'd3, v); check("R8", "direction after async reset", v, 8'hFF);
    readReg(2'd1, v); check("R8", "output after async reset", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrite();
    testIdx0Write();
    testInputPolarity();
    testSyncDelay();
    testSnapshot();
    testOutReadback();
    testOpenDrain();
    testSyncReset();
    testAsyncReset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule